// File: doc/BRIEF.md
# Comfort Noise Level Tracker and Injector

This block follows the background level of a stream of signed 16-bit samples and, whenever a nonlinear processor is suppressing that stream, puts synthetic noise at a matching level in place of the removed signal. Each sample arrives with a one-cycle strobe. The block returns one registered output sample, together with an output strobe, one clock later. When suppression is off, the input sample is copied to the output unchanged. When suppression is on, the output is scaled pseudo-random noise, or silence if injection has been switched off.

The level estimate follows the magnitude of each strobed sample. Exponential mode moves it by a shifted fraction of the gap to the target. Linear mode moves it by a fixed step. Two guard inputs, one for double-talk and one for uncancelled echo, can freeze the estimate. This keeps speech or leftover echo out of the background estimate. Each guard has its own enable bit.

Top module: `comfort_noise_inj`

## Requirements
- R1: While `nlp_active` is 1 and `inj_off` is 1, a strobed sample produces an output of 0.
- R2: Every `smp_valid` pulse produces exactly one `out_valid` pulse on the next clock. When `nlp_active` was 0 for that sample, `smp_out` equals `smp_in`.
- R3: When `ramp_exp` is 1 (exponential), an unfrozen strobe sets level = level + ((|x| − level) >>> `ramp_rate`). The shift is arithmetic, so a rate of 0 jumps straight to |x|.
- R4: When `ramp_exp` is 0 (linear), an unfrozen strobe moves the level toward |x| by `ramp_rate`+1. If the gap is no larger than that step, the level lands exactly on |x| and never passes it.
- R5: The level changes only on a strobe. The target is the magnitude of the input, and the magnitude of −32768 is 32768.
- R6: If `guard_dt_en` is 1 and `dt_flag` is 1 on a strobe, the level keeps its value. If `guard_dt_en` is 0, `dt_flag` has no effect.
- R7: If `guard_echo_en` is 1 and `echo_flag` is 1 on a strobe, the level keeps its value. If `guard_echo_en` is 0, `echo_flag` has no effect.
- R8: The noise source is a 16-bit register that shifts left by one on every strobe, whatever the other inputs are. Its new bit 0 is the XOR of bits 15, 13, 12 and 10. It is loaded with 0xACE1 at reset and is never zero.
- R9: While `nlp_active` is 1 and `inj_off` is 0, the output is saturate16((signed noise × level × `noise_gain`) >>> 16). The noise register and level used are the values held before that strobe updates them.
- R10: A synchronous active-high `rst` clears the level to 0, clears `smp_out` and `out_valid` to 0, and loads the noise seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_in | input | 16 | Signed input sample |
| nlp_active | input | 1 | Suppression currently applied |
| dt_flag | input | 1 | Double-talk present |
| echo_flag | input | 1 | Residual echo present |
| inj_off | input | 1 | 1 = output silence instead of noise |
| ramp_exp | input | 1 | 1 = exponential ramp, 0 = linear ramp |
| ramp_rate | input | 4 | Shift amount (exponential) or step−1 (linear) |
| noise_gain | input | 8 | Unsigned noise amplitude multiplier |
| guard_dt_en | input | 1 | Enable the double-talk freeze |
| guard_echo_en | input | 1 | Enable the residual-echo freeze |
| smp_out | output | 16 | Signed output sample |
| out_valid | output | 1 | Output sample strobe |

## Verification
The hardest state to reach from the ports is a frozen estimate, because the level cannot be read directly. The stimulus first drives the level to a known value using exponential mode at rate 0. It then strobes very different samples with a guard flag raised, and afterwards observes the injected noise. That noise is scaled by the level, so a level that did not freeze shows up as a mismatch. The same method exposes the linear no-overshoot corner, where targets sit one unit past a multiple of the step, and the saturation corner, where the level is 32768 and the gain is 255.

// File: rtl/cn_pkg.sv
package cn_pkg;
    localparam int DATA_W = 16;
    localparam int RATE_W = 4;
    localparam int GAIN_W = 8;
    localparam int PROD_W = 2 * DATA_W + GAIN_W + 2;
    localparam logic [DATA_W-1:0] LFSR_SEED = 16'hACE1;
    localparam logic [DATA_W-1:0] LFSR_TAPS = 16'hB400;

    typedef enum logic {RAMP_LIN = 1'b0, RAMP_EXP = 1'b1} ramp_e;
    typedef logic signed [DATA_W-1:0] smp_t;
    typedef logic        [DATA_W-1:0] mag_t;

    typedef struct packed {
        logic upd;
        logic adv;
    } step_ctl_t;

    localparam logic signed [PROD_W-1:0] SMAX = {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] SMIN = {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    function automatic mag_t abs_mag(input smp_t x);
        return x[DATA_W-1] ? mag_t'(~x + 1'b1) : mag_t'(x);
    endfunction

    function automatic smp_t sat_smp(input logic signed [PROD_W-1:0] v);
        if (v > SMAX)      return {1'b0, {(DATA_W-1){1'b1}}};
        else if (v < SMIN) return {1'b1, {(DATA_W-1){1'b0}}};
        else               return v[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/cn_level_track.sv
module cn_level_track
    import cn_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  ramp_e         mode,
    input  logic [RW-1:0] rate,
    input  logic [W-1:0]  tgt,
    output logic [W-1:0]  lvl
);
    localparam int DW = W + 2;

    logic [W-1:0]          lvl_q;
    logic [W-1:0]          lvl_d;
    logic signed [DW-1:0]  cur;
    logic signed [DW-1:0]  diff;
    logic signed [DW-1:0]  exp_step;
    logic signed [DW-1:0]  lin_step;
    logic signed [DW-1:0]  sum;

    always_comb begin
        cur      = $signed({2'b00, lvl_q});
        diff     = $signed({2'b00, tgt}) - cur;
        exp_step = diff >>> rate;
        lin_step = {{(DW-RW){1'b0}}, rate} + 1'b1;
        sum      = cur;
        if (mode == RAMP_EXP) begin
            sum = cur + exp_step;
        end else if (diff > lin_step) begin
            sum = cur + lin_step;
        end else if (diff < -lin_step) begin
            sum = cur - lin_step;
        end else begin
            sum = $signed({2'b00, tgt});
        end
        lvl_d = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)      lvl_q <= '0;
        else if (upd) lvl_q <= lvl_d;
    end

    assign lvl = lvl_q;
endmodule

// File: rtl/cn_noise_lfsr.sv
module cn_noise_lfsr
    import cn_pkg::*;
#(
    parameter int              W    = DATA_W,
    parameter logic [W-1:0]    SEED = LFSR_SEED,
    parameter logic [W-1:0]    TAPS = LFSR_TAPS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] state
);
    logic [W-1:0] st_q;
    logic         fb;

    assign fb = ^(st_q & TAPS);

    always_ff @(posedge clk) begin
        if (rst)      st_q <= SEED;
        else if (adv) st_q <= {st_q[W-2:0], fb};
    end

    assign state = st_q;
endmodule

// File: rtl/cn_noise_scale.sv
module cn_noise_scale
    import cn_pkg::*;
(
    input  logic [DATA_W-1:0] lfsr,
    input  logic [DATA_W-1:0] lvl,
    input  logic [GAIN_W-1:0] gain,
    output smp_t              noise
);
    logic signed [PROD_W-1:0] a_s;
    logic signed [PROD_W-1:0] b_s;
    logic signed [PROD_W-1:0] c_s;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        a_s   = PROD_W'($signed(lfsr));
        b_s   = {{(PROD_W-DATA_W){1'b0}}, lvl};
        c_s   = {{(PROD_W-GAIN_W){1'b0}}, gain};
        prod  = a_s * b_s * c_s;
        noise = sat_smp(prod >>> DATA_W);
    end
endmodule

// File: rtl/comfort_noise_inj.sv
module comfort_noise_inj
    import cn_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] smp_in,
    input  logic                     nlp_active,
    input  logic                     dt_flag,
    input  logic                     echo_flag,
    input  logic                     inj_off,
    input  logic                     ramp_exp,
    input  logic [RATE_W-1:0]        ramp_rate,
    input  logic [GAIN_W-1:0]        noise_gain,
    input  logic                     guard_dt_en,
    input  logic                     guard_echo_en,
    output logic signed [DATA_W-1:0] smp_out,
    output logic                     out_valid
);
    step_ctl_t         ctl;
    logic              frozen;
    logic [DATA_W-1:0] lvl_q;
    logic [DATA_W-1:0] lfsr_q;
    smp_t              noise;
    smp_t              out_d;
    ramp_e             mode;

    assign frozen  = (guard_dt_en & dt_flag) | (guard_echo_en & echo_flag);
    assign ctl.upd = smp_valid & ~frozen;
    assign ctl.adv = smp_valid;
    assign mode    = ramp_e'(ramp_exp);

    cn_level_track #(.W(DATA_W), .RW(RATE_W)) u_track (
        .clk  (clk),
        .rst  (rst),
        .upd  (ctl.upd),
        .mode (mode),
        .rate (ramp_rate),
        .tgt  (abs_mag(smp_in)),
        .lvl  (lvl_q)
    );

    cn_noise_lfsr #(.W(DATA_W)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .adv   (ctl.adv),
        .state (lfsr_q)
    );

    cn_noise_scale u_scale (
        .lfsr  (lfsr_q),
        .lvl   (lvl_q),
        .gain  (noise_gain),
        .noise (noise)
    );

    always_comb begin
        if (!nlp_active)  out_d = smp_in;
        else if (inj_off) out_d = '0;
        else              out_d = noise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_out   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid) smp_out <= out_d;
        end
    end
endmodule

// File: rtl/cn_checker.sv
module cn_checker
    import cn_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     smp_valid,
    input logic signed [DATA_W-1:0] smp_in,
    input logic                     nlp_active,
    input logic                     dt_flag,
    input logic                     echo_flag,
    input logic                     inj_off,
    input logic                     ramp_exp,
    input logic [RATE_W-1:0]        ramp_rate,
    input logic                     guard_dt_en,
    input logic                     guard_echo_en,
    input logic signed [DATA_W-1:0] smp_out,
    input logic                     out_valid,
    input logic [DATA_W-1:0]        lvl,
    input logic [DATA_W-1:0]        lfsr
);
    logic              armed;
    logic              hold;
    logic [DATA_W-1:0] mag;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assign hold = (guard_dt_en && dt_flag) || (guard_echo_en && echo_flag);
    assign mag  = smp_in[DATA_W-1] ? DATA_W'(-smp_in) : DATA_W'(smp_in);

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == $past(smp_valid)));

    p_pass_through_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(smp_valid && !nlp_active)) |-> (smp_out == $past(smp_in)));

    p_silence_r1: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(smp_valid && nlp_active && inj_off)) |-> (smp_out == '0));

    p_exp_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(smp_valid && ramp_exp && !hold && ramp_rate == '0)) |-> (lvl == $past(mag)));

    p_no_overshoot_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(smp_valid && !ramp_exp && !hold) && ($past(lvl) <= $past(mag)))
        |-> ((lvl <= $past(mag)) && (lvl >= $past(lvl))));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(smp_valid)) |-> $stable(lvl));

    p_guard_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(smp_valid && guard_dt_en && dt_flag)) |-> $stable(lvl));

    p_guard_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(smp_valid && guard_echo_en && echo_flag)) |-> $stable(lvl));

    p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        armed |-> (lfsr != '0));
endmodule

bind comfort_noise_inj cn_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .smp_valid     (smp_valid),
    .smp_in        (smp_in),
    .nlp_active    (nlp_active),
    .dt_flag       (dt_flag),
    .echo_flag     (echo_flag),
    .inj_off       (inj_off),
    .ramp_exp      (ramp_exp),
    .ramp_rate     (ramp_rate),
    .guard_dt_en   (guard_dt_en),
    .guard_echo_en (guard_echo_en),
    .smp_out       (smp_out),
    .out_valid     (out_valid),
    .lvl           (lvl_q),
    .lfsr          (lfsr_q)
);

// File: tb/comfort_noise_inj_tb_top.sv
`timescale 1ns/1ps
module comfort_noise_inj_tb_top;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_valid = 1'b0;
    logic signed [15:0] smp_in = '0;
    logic               nlp_active = 1'b0;
    logic               dt_flag = 1'b0;
    logic               echo_flag = 1'b0;
    logic               inj_off = 1'b0;
    logic               ramp_exp = 1'b1;
    logic [3:0]         ramp_rate = '0;
    logic [7:0]         noise_gain = 8'd64;
    logic               guard_dt_en = 1'b1;
    logic               guard_echo_en = 1'b1;
    logic signed [15:0] smp_out;
    logic               out_valid;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic signed [15:0] val;
        int                 req;
    } exp_item_t;
    exp_item_t sb_q[$];

    int          m_level = 0;
    logic [15:0] m_lfsr  = 16'hACE1;

    always #10 clk = ~clk;

    comfort_noise_inj dut_i (
        .clk           (clk),
        .rst           (rst),
        .smp_valid     (smp_valid),
        .smp_in        (smp_in),
        .nlp_active    (nlp_active),
        .dt_flag       (dt_flag),
        .echo_flag     (echo_flag),
        .inj_off       (inj_off),
        .ramp_exp      (ramp_exp),
        .ramp_rate     (ramp_rate),
        .noise_gain    (noise_gain),
        .guard_dt_en   (guard_dt_en),
        .guard_echo_en (guard_echo_en),
        .smp_out       (smp_out),
        .out_valid     (out_valid)
    );

    // Noise per R9: saturate((signed noise * level * gain) >>> 16)
    function automatic logic signed [15:0] model_noise(input logic [15:0] l, input int lev, input int g);
        longint p;
        p = longint'($signed(l)) * longint'(lev) * longint'(g);
        p = p >>> 16;
        if (p > 32767)  return 16'sh7FFF;
        if (p < -32768) return 16'sh8000;
        return p[15:0];
    endfunction

    // Driver: computes the expected output from R1/R2/R9, then updates the model per R3-R8
    task automatic send(input logic signed [15:0] s, input bit nlp, input bit dt, input bit ec, input int req);
        exp_item_t it;
        int tgt;
        int step;
        @(negedge clk);
        smp_in     = s;
        nlp_active = nlp;
        dt_flag    = dt;
        echo_flag  = ec;
        smp_valid  = 1'b1;
        if (!nlp)         it.val = s;
        else if (inj_off) it.val = '0;
        else              it.val = model_noise(m_lfsr, m_level, int'(noise_gain));
        it.req = req;
        sb_q.push_back(it);
        tgt = (s < 0) ? -int'(s) : int'(s);
        if (!((guard_dt_en && dt) || (guard_echo_en && ec))) begin
            if (ramp_exp) begin
                m_level = m_level + ((tgt - m_level) >>> ramp_rate);
            end else begin
                step = int'(ramp_rate) + 1;
                if (tgt - m_level > step)       m_level = m_level + step;
                else if (m_level - tgt > step)  m_level = m_level - step;
                else                            m_level = tgt;
            end
        end
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // R5: idle cycles with a changing input but no strobe
    task automatic idle(input int n, input logic signed [15:0] v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_in     = v;
            nlp_active = 1'b1;
        end
    endtask

    // Monitor: pops the scoreboard on each output strobe
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_item_t it;
            tests++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected out_valid: actual %0d expected none", smp_out);
            end else begin
                it = sb_q.pop_front();
                if (smp_out !== it.val) begin
                    fails++;
                    $display("FAIL R%0d sample: actual %0d expected %0d", it.req, smp_out, it.val);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        tests++;
        if (smp_out !== 16'sd0 || out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset: actual out=%0d valid=%0b expected out=0 valid=0", smp_out, out_valid);
        end

        // R2: pass-through with several patterns; R5 magnitude of the most negative value
        ramp_exp = 1'b1; ramp_rate = 4'd0; noise_gain = 8'd64;
        send(16'sd100, 0, 0, 0, 2);
        send(-16'sd32768, 0, 0, 0, 5);
        send(16'sd32767, 0, 0, 0, 2);
        send(-16'sd5, 0, 0, 0, 2);

        // R9, R3: exponential jump at rate 0 then noise
        send(16'sd1000, 1, 0, 0, 3);
        for (int i = 0; i < 5; i++) send(16'sd1000, 1, 0, 0, 9);

        // R3: exponential with rate 3
        ramp_rate = 4'd3;
        for (int i = 0; i < 6; i++) send(16'sd20000, 1, 0, 0, 3);

        // R5: idle cycles must not move the level
        idle(5, 16'sd7777);
        send(16'sd20000, 1, 0, 0, 5);

        // R4: linear ramp and no overshoot
        ramp_rate = 4'd0;
        send(16'sd0, 1, 0, 0, 3);
        ramp_exp = 1'b0; ramp_rate = 4'd2; noise_gain = 8'd255;
        for (int i = 0; i < 5; i++) send(16'sd10, 1, 0, 0, 4);
        for (int i = 0; i < 4; i++) send(-16'sd2, 1, 0, 0, 4);

        // R6: double-talk freeze, then guard disabled
        ramp_exp = 1'b1; ramp_rate = 4'd0; noise_gain = 8'd64;
        send(16'sd5000, 1, 0, 0, 3);
        for (int i = 0; i < 3; i++) send(16'sd30000, 1, 1, 0, 6);
        send(16'sd30000, 1, 0, 0, 6);
        send(16'sd5000, 1, 0, 0, 6);
        guard_dt_en = 1'b0;
        for (int i = 0; i < 3; i++) send(16'sd30000, 1, 1, 0, 6);
        guard_dt_en = 1'b1;

        // R7: residual-echo freeze, then guard disabled
        send(16'sd4000, 1, 0, 0, 3);
        for (int i = 0; i < 3; i++) send(-16'sd25000, 1, 0, 1, 7);
        send(16'sd4000, 1, 0, 0, 7);
        guard_echo_en = 1'b0;
        for (int i = 0; i < 3; i++) send(-16'sd25000, 1, 0, 1, 7);
        guard_echo_en = 1'b1;

        // R1: injection off gives silence; pass-through still works
        inj_off = 1'b1;
        for (int i = 0; i < 3; i++) send(16'sd1234, 1, 0, 0, 1);
        send(16'sd1234, 0, 0, 0, 2);
        inj_off = 1'b0;

        // R9, R8: saturation at full level and gain
        noise_gain = 8'd255;
        send(-16'sd32768, 1, 0, 0, 5);
        for (int i = 0; i < 8; i++) send(-16'sd32768, 1, 0, 0, 8);

        repeat (3) @(negedge clk);
        tests++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing outputs: actual %0d pending expected 0", sb_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule